// File: doc/BRIEF.md
# Character LCD Power-Up and Greeting Sequencer

This block drives an 8-bit parallel character display module of the 16x2 kind with no processor involved. After reset it issues four setup commands to the display and then writes four characters. It moves through a fixed list of eight transfers, one transfer at a time. For each transfer it places the byte and the register-select level on the bus and waits one clock. It then raises the enable strobe for a counted number of clocks and lowers it. It keeps the bus unchanged for a counted settle time before it starts the next transfer. When the list is finished it parks with the strobe low and raises a done flag.

The strobe width and the settle time are given in nanoseconds and microseconds. The block converts them to clock counts from the clock frequency parameter, so the same code meets the display's timing at any clock rate. The settle time defaults to 2 ms, which is long enough for the slowest command, the screen clear. The block never reads the display's busy flag.

Top module: `lcd_seq_top`

## Requirements
- R1: The first four transfers are commands, in this order: 0x38, 0x01, 0x06, 0x0C.
- R2: After the commands, the character bytes 0x53, 0x48, 0x52, 0x49 ("SHRI") are written in that order, which makes eight strobes in total.
- R3: `lcd_rs` is 0 during a command strobe and 1 during a character strobe. `lcd_rw` is 0 in every cycle (write only).
- R4: Each enable pulse stays high for exactly ceil(PULSE_NS x CLK_HZ / 1e9) clocks, with a minimum of one.
- R5: `lcd_data` and `lcd_rs` hold their transfer value for one clock before `lcd_en` rises and stay unchanged for the whole high time.
- R6: After `lcd_en` falls, the bus keeps the same byte and the enable stays low for SETTLE_US x CLK_HZ / 1e6 clocks. The next enable rises one clock after that (one setup clock).
- R7: Once the last character's settle time ends, `seq_done` is 1. It stays 1 with `lcd_en` low and the bus showing 0x49 until the next reset, and no further pulse occurs.
- R8: Reset is synchronous and active low. While it is applied, `lcd_en` and `seq_done` are 0 and the bus shows 0x38 with `lcd_rs` 0. On release, one setup clock follows, then the first pulse. A reset applied in the middle of the sequence restarts it from the first command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, frequency given by CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| lcd_data | output | 8 | Byte presented to the display |
| lcd_rs | output | 1 | Register select: 0 command, 1 character |
| lcd_rw | output | 1 | Read/write select, held at 0 |
| lcd_en | output | 1 | Enable strobe, high during a transfer pulse |
| seq_done | output | 1 | High once the whole list has been sent |

## Verification
The bench builds the block twice from the same clock. One copy has CLK_HZ at 10 MHz and a 3 us settle, so the 450 ns pulse rounds up from 4.5 to 5 clocks and the hold is 30 clocks. The other copy has CLK_HZ at 20 MHz and a 2 us settle, so the pulse count comes out exactly at 9 clocks and the hold is 40 clocks. These short holds keep the whole eight-transfer list to a few hundred cycles. That makes room for repeated resets at random points, including one inside a pulse and one in the first setup clock, followed by a full run to the done state.

// File: rtl/lcd_seq_pkg.sv
// Shared definitions for the LCD sequencer.
// It holds the phase encoding, the length of the transfer list and the byte
// sent at each step. It assumes the commands come first in the list.
package lcd_seq_pkg;

    typedef enum logic [1:0] {
        PH_SETUP = 2'd0,
        PH_PULSE = 2'd1,
        PH_HOLD  = 2'd2,
        PH_DONE  = 2'd3
    } lcd_phase_e;

    localparam int unsigned NUM_STEPS = 8;
    localparam int unsigned NUM_CMDS  = 4;
    localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

    // Byte for each list position: commands, then the characters.
    function automatic logic [7:0] step_byte(input logic [STEP_W-1:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h38;
            3'd1:    b = 8'h01;
            3'd2:    b = 8'h06;
            3'd3:    b = 8'h0C;
            3'd4:    b = 8'h53;
            3'd5:    b = 8'h48;
            3'd6:    b = 8'h52;
            default: b = 8'h49;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcd_byte_rom.sv
// Maps a step index to the bus byte and the register-select level.
// Purely combinational. It assumes commands occupy indices below NUM_CMDS.
module lcd_byte_rom
    import lcd_seq_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    output logic [7:0]        byte_o,
    output logic              rs_o
);

    // Decode the byte and its kind for the current step.
    always_comb begin
        byte_o = step_byte(step_i);
        rs_o   = ({{(32-STEP_W){1'b0}}, step_i} >= NUM_CMDS);
    end

endmodule

// File: rtl/lcd_strobe_timer.sv
// Cycle counter shared by the pulse and settle phases.
// It counts while run_i is high and flags the cycle in which the count equals
// last_i. The count clears when run_i is low or when the flag is raised, so
// each phase lasts last_i + 1 clocks. It assumes last_i is stable within a phase.
module lcd_strobe_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [CW-1:0] last_i,
    output logic          at_last_o
);

    logic [CW-1:0] cnt_q;

    assign at_last_o = run_i && (cnt_q == last_i);

    // Count clocks inside a phase and restart at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || at_last_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: the count never passes the phase limit.
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q <= last_i));

    // R4: an idle cycle leaves the counter cleared for the next phase.
    a_r4_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/lcd_seq_fsm.sv
// Phase and step control for the LCD sequencer.
// Each transfer passes through setup (one clock), pulse (HIGH_CYC clocks) and
// hold (SETTLE_CYC clocks). After the last step it parks in the done phase.
// It assumes HIGH_CYC and SETTLE_CYC are at least 1 and fit in CW bits.
module lcd_seq_fsm
    import lcd_seq_pkg::*;
#(
    parameter int CW         = 8,
    parameter int HIGH_CYC   = 1,
    parameter int SETTLE_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STEP_W-1:0] step_o,
    output logic              en_o,
    output logic              done_o
);

    localparam logic [CW-1:0]     HIGH_LAST   = CW'(HIGH_CYC - 1);
    localparam logic [CW-1:0]     SETTLE_LAST = CW'(SETTLE_CYC - 1);
    localparam logic [STEP_W-1:0] LAST_STEP   = STEP_W'(NUM_STEPS - 1);

    lcd_phase_e        phase_q;
    logic [STEP_W-1:0] step_q;
    logic              run;
    logic [CW-1:0]     limit;
    logic              at_last;

    // Select the timer's activity and limit for the current phase.
    always_comb begin
        run   = (phase_q == PH_PULSE) || (phase_q == PH_HOLD);
        limit = (phase_q == PH_PULSE) ? HIGH_LAST : SETTLE_LAST;
    end

    lcd_strobe_timer #(.CW(CW)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .last_i    (limit),
        .at_last_o (at_last)
    );

    // Advance the phase and the step index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_SETUP;
            step_q  <= '0;
        end else begin
            case (phase_q)
                PH_SETUP: phase_q <= PH_PULSE;
                PH_PULSE: if (at_last) phase_q <= PH_HOLD;
                PH_HOLD: begin
                    if (at_last) begin
                        if (step_q == LAST_STEP) begin
                            phase_q <= PH_DONE;
                        end else begin
                            step_q  <= step_q + 1'b1;
                            phase_q <= PH_SETUP;
                        end
                    end
                end
                default: phase_q <= PH_DONE;
            endcase
        end
    end

    assign step_o = step_q;
    assign en_o   = (phase_q == PH_PULSE);
    assign done_o = (phase_q == PH_DONE);

    // R7: the done phase lasts until reset and never strobes.
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (done_o && !en_o));

    // R7: done is entered only from the hold of the final step.
    a_r7_done_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (step_q == LAST_STEP));

endmodule

// File: rtl/lcd_seq_top.sv
// Character LCD power-up and greeting sequencer, top level.
// It converts the timing parameters into clock counts and joins the control
// FSM with the byte table. It assumes a free-running clock of CLK_HZ and that
// the display is powered before reset is released.
module lcd_seq_top
    import lcd_seq_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int PULSE_NS  = 450,
    parameter int SETTLE_US = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [7:0] lcd_data,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en,
    output logic       seq_done
);

    localparam longint HIGH_RAW   = (longint'(PULSE_NS) * longint'(CLK_HZ) + 64'sd999_999_999)
                                    / 64'sd1_000_000_000;
    localparam longint SETTLE_RAW = (longint'(SETTLE_US) * longint'(CLK_HZ)) / 64'sd1_000_000;
    localparam int     HIGH_CYC   = (HIGH_RAW < 1) ? 1 : int'(HIGH_RAW);
    localparam int     SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : int'(SETTLE_RAW);
    localparam int     MAX_CYC    = (HIGH_CYC > SETTLE_CYC) ? HIGH_CYC : SETTLE_CYC;
    localparam int     CW         = $clog2(MAX_CYC + 1);

    logic [STEP_W-1:0] step;

    lcd_seq_fsm #(
        .CW         (CW),
        .HIGH_CYC   (HIGH_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_o (step),
        .en_o   (lcd_en),
        .done_o (seq_done)
    );

    lcd_byte_rom rom_i (
        .step_i (step),
        .byte_o (lcd_data),
        .rs_o   (lcd_rs)
    );

    assign lcd_rw = 1'b0;

    // R5: the bus was already valid in the clock before the strobe rose.
    a_r5_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_en) |-> ($stable(lcd_data) && $stable(lcd_rs)));

    // R5: the bus does not move while the strobe is high.
    a_r5_high_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_en && $past(lcd_en)) |-> ($stable(lcd_data) && $stable(lcd_rs)));

    // R6: the bus is still unchanged in the first clock after the strobe falls.
    a_r6_fall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_en) |-> ($stable(lcd_data) && $stable(lcd_rs)));

endmodule

// File: tb/lcd_seq_top_tb_top.sv
// Per-instance observer: rebuilds the expected transfer list and timing from
// the requirements and counts its own checks and failures.
module lcd_seq_mon #(
    parameter int    HIGH   = 1,
    parameter int    SETTLE = 1,
    parameter string TAG    = "A"
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] data,
    input  logic       rs,
    input  logic       rw,
    input  logic       en,
    input  logic       done,
    output int         n_chk,
    output int         n_err
);

    int         chk_cnt  = 0;
    int         err_cnt  = 0;
    int         idx      = 0;
    int         hi_len   = 0;
    int         lo_len   = 0;
    logic       prev_en  = 1'b0;
    logic       prev_rst = 1'b0;
    logic [7:0] prev_data = 8'h00;

    assign n_chk = chk_cnt;
    assign n_err = err_cnt;

    function automatic logic [7:0] exp_byte(input int i);
        case (i)
            0: return 8'h38;
            1: return 8'h01;
            2: return 8'h06;
            3: return 8'h0C;
            4: return 8'h53;
            5: return 8'h48;
            6: return 8'h52;
            default: return 8'h49;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        chk_cnt++;
        if (!ok) begin
            err_cnt++;
            $display("FAIL [%s] %s actual=0x%0h expected=0x%0h at %0t", TAG, req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            if (!prev_rst) begin
                chk(!en, "R8 enable low in reset", int'(en), 0);
                chk(!done, "R8 done low in reset", int'(done), 0);
                chk(data == 8'h38 && !rs, "R8 bus shows first command in reset",
                    int'({rs, data}), 'h038);
            end
            idx     = 0;
            hi_len  = 0;
            lo_len  = 0;
            prev_en = 1'b0;
        end else begin
            chk(!rw, "R3 rw held low", int'(rw), 0);
            if (en && !prev_en) begin
                if (idx >= 8) begin
                    chk(1'b0, "R7 no pulse after list end", idx, 8);
                end else begin
                    chk(data == exp_byte(idx), (idx < 4) ? "R1 command byte" : "R2 character byte",
                        int'(data), int'(exp_byte(idx)));
                    chk(rs == (idx >= 4), "R3 rs level", int'(rs), int'(idx >= 4));
                end
                chk(data == prev_data, "R5 bus set one clock before strobe", int'(data), int'(prev_data));
                chk(lo_len == ((idx == 0) ? 1 : SETTLE + 1), "R6 low time before strobe",
                    lo_len, (idx == 0) ? 1 : SETTLE + 1);
                hi_len = 1;
            end else if (en) begin
                hi_len++;
                chk(data == prev_data, "R5 bus stable while strobe high", int'(data), int'(prev_data));
            end else if (prev_en) begin
                chk(hi_len == HIGH, "R4 strobe width", hi_len, HIGH);
                idx++;
                lo_len = 1;
            end else begin
                lo_len++;
            end
            if (!en && idx > 0 && (lo_len <= SETTLE || idx == 8)) begin
                chk(data == exp_byte(idx - 1), (idx == 8 && lo_len > SETTLE) ?
                    "R7 last byte kept when done" : "R6 bus held after strobe",
                    int'(data), int'(exp_byte(idx - 1)));
            end
            chk(done == (idx == 8 && lo_len > SETTLE), "R7 done flag timing",
                int'(done), int'(idx == 8 && lo_len > SETTLE));
            prev_en = en;
        end
        prev_data = data;
        prev_rst  = rst_n;
    end

endmodule

// Bench top: random resets with a fixed seed plus directed corner cases.
module lcd_seq_top_tb_top;

    localparam int CLK_PERIOD_NS = 100;
    localparam int WATCHDOG      = 20000;

    localparam int HZ_A = 10_000_000;
    localparam int ST_A = 3;
    localparam int HZ_B = 20_000_000;
    localparam int ST_B = 2;

    function automatic int pulse_clocks(input longint hz);
        longint c;
        c = (450 * hz + 999_999_999) / 1_000_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction

    function automatic int settle_clocks(input longint us, input longint hz);
        longint c;
        c = (us * hz) / 1_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction

    localparam int HIGH_A   = pulse_clocks(HZ_A);
    localparam int SETTLE_A = settle_clocks(ST_A, HZ_A);
    localparam int HIGH_B   = pulse_clocks(HZ_B);
    localparam int SETTLE_B = settle_clocks(ST_B, HZ_B);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data_a, data_b;
    logic       rs_a, rs_b, rw_a, rw_b, en_a, en_b, done_a, done_b;
    int         ca, ea, cb, eb;
    int         my_chk = 0;
    int         my_err = 0;

    always #(CLK_PERIOD_NS / 2) clk = ~clk;

    lcd_seq_top #(.CLK_HZ(HZ_A), .PULSE_NS(450), .SETTLE_US(ST_A)) dut_i (
        .clk (clk), .rst_n (rst_n), .lcd_data (data_a), .lcd_rs (rs_a),
        .lcd_rw (rw_a), .lcd_en (en_a), .seq_done (done_a)
    );

    lcd_seq_top #(.CLK_HZ(HZ_B), .PULSE_NS(450), .SETTLE_US(ST_B)) dut_fast_i (
        .clk (clk), .rst_n (rst_n), .lcd_data (data_b), .lcd_rs (rs_b),
        .lcd_rw (rw_b), .lcd_en (en_b), .seq_done (done_b)
    );

    lcd_seq_mon #(.HIGH(HIGH_A), .SETTLE(SETTLE_A), .TAG("10MHz")) mon_a_i (
        .clk (clk), .rst_n (rst_n), .data (data_a), .rs (rs_a), .rw (rw_a),
        .en (en_a), .done (done_a), .n_chk (ca), .n_err (ea)
    );

    lcd_seq_mon #(.HIGH(HIGH_B), .SETTLE(SETTLE_B), .TAG("20MHz")) mon_b_i (
        .clk (clk), .rst_n (rst_n), .data (data_b), .rs (rs_b), .rw (rw_b),
        .en (en_b), .done (done_b), .n_chk (cb), .n_err (eb)
    );

    task automatic tchk(input bit ok, input string req, input int act, input int exp);
        my_chk++;
        if (!ok) begin
            my_err++;
            $display("FAIL [top] %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        int waited;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R8: random restarts at arbitrary points of the list.
        for (int t = 0; t < 6; t++) begin
            repeat ($urandom_range(420, 3)) @(posedge clk);
            #1 rst_n = 1'b0;
            repeat ($urandom_range(4, 2)) @(posedge clk);
            #1 rst_n = 1'b1;
        end
        // R8: directed reset inside the first strobe of the slower copy.
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        // R8: directed reset during the very first setup clock.
        @(posedge clk);
        #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        // R7: full run to the end of the list, bounded by the watchdog.
        waited = 0;
        while (!(done_a && done_b) && waited < WATCHDOG) begin
            @(posedge clk);
            waited++;
        end
        tchk(waited < WATCHDOG, "R7 watchdog: list finished", waited, WATCHDOG);
        repeat (25) @(posedge clk);
        @(negedge clk);
        tchk(done_a && done_b, "R7 done still set", int'({done_a, done_b}), 3);
        tchk(!en_a && !en_b, "R7 strobe parked low", int'({en_a, en_b}), 0);
        tchk(data_a == 8'h49 && data_b == 8'h49, "R7 last character on bus",
             int'(data_a), 'h49);
        $display("CHECKS %0d ERRORS %0d", my_chk + ca + cb, my_err + ea + eb);
        $finish;
    end

endmodule